// File: doc/BRIEF.md
# Power-Save Entry and Wake Sequencer

This block takes a clock generator from normal running into one of four low-power modes (IDLE, WATCH, Sub-WATCH, STOP) and back. Software raises a one-cycle standby request together with a mode code. The sequencer then steps through a latch stage, an accept stage and a clock-stop stage that lasts a set number of cycles, and finally reaches the low-power stage. In the low-power stage it asserts the PLL and spread-spectrum stop outputs for every mode except IDLE.

A wake event can arrive at any point in this sequence. If it is seen in the latch stage, the request is dropped and nothing changes. If it is seen in the accept or clock-stop stage, the wake-up register values are applied but the completion flag stays 0, so the clocks never stopped. If it is seen in the low-power stage, the wake-up values are applied and the completion flag reads 1. Software reads the completion flag after wake-up to learn which of these outcomes occurred.

The block also holds the clock configuration registers. Writes that come from a DMA master are rejected. The CPU clock code may be written only once after reset and once after each applied wake. The peripheral clock selections may be written only once after reset.

Top module: `pwrsave_seq`

## Requirements
- R1: A wake sampled while `seq_stage` is 1 (latch) returns the stage to 0 (run) on the next cycle. The registers, the completion flag and the stop outputs keep their values, and the CPU clock write lock is not re-armed.
- R2: Stage codes are 0 run, 1 latch, 2 accept, 3 clock-stop and 4 low-power. A standby request in run moves to latch. With no wake, the sequence is one latch cycle, one accept cycle, exactly STOP_CYC clock-stop cycles, and then low-power. Reset gives stage 0 with all registers and flags at 0.
- R3: A wake sampled in accept or clock-stop returns to run and applies the wake-up register values. The completion flag reads 0, and the stop outputs never rose.
- R4: The completion flag clears on entry to accept and sets on entry to low-power, and a wake leaves it unchanged. In low-power, `pll_stop` and `sscg_stop` are 1 for mode codes 1 (WATCH), 2 (Sub-WATCH) and 3 (STOP), and 0 for code 0 (IDLE).
- R5: An applied wake from WATCH, Sub-WATCH or STOP clears register 0 (bit0 PLL enable, bit1 spread enable, bit2 peripheral clock select) and register 1 (two SW-bit source fields). An applied wake from IDLE leaves both registers unchanged.
- R6: An applied wake from IDLE or STOP sets the 3-bit CPU clock code (register 2, bits [2:0]) to 000.
- R7: An applied wake from WATCH or Sub-WATCH sets the CPU clock code to 000 when `osc_off` is 0 and to 100 when `osc_off` is 1.
- R8: Only the first write to register 2 after reset or after an applied wake takes effect, and later writes are ignored. When an applied wake and a write fall in the same cycle, the wake value wins.
- R9: Register 3 holds three PW-bit peripheral clock fields. Only the first write after reset takes effect, and wakes do not re-arm it.
- R10: A write with `wr_dma` high changes no register.
- R11: A standby request outside run is ignored, and a wake in run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_req | input | 1 | One-cycle standby request |
| mode_sel | input | 2 | Target mode: 0 IDLE, 1 WATCH, 2 Sub-WATCH, 3 STOP |
| wake | input | 1 | Wake-up event |
| osc_off | input | 1 | Main oscillator disable control |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index 0..3 |
| wr_data | input | DW | Write data |
| wr_dma | input | 1 | Write is issued by a DMA master |
| seq_stage | output | 3 | Sequencer stage code |
| pll_stop | output | 1 | PLL stop request |
| sscg_stop | output | 1 | Spread-spectrum generator stop request |
| done_flag | output | 1 | Entry fully completed |
| ctl_bits | output | 3 | Register 0 contents |
| src_sel | output | 2*SW | Register 1 contents |
| cpu_code | output | 3 | Register 2 contents |
| per_sel | output | 3*PW | Register 3 contents |

## Verification
Every result is due one clock edge after the stimulus that causes it. Stage moves, flag changes, wake-up register values and accepted writes all appear after the edge that samples the request, the wake or the write. The stop outputs follow the low-power stage with no further delay. The bench drives inputs just after a rising edge and updates its reference model for the next edge. It compares every output 2 ns after that edge, so each comparison sees exactly one edge of effect. The directed steps count `STOP_CYC + 2` edges from latch to low-power, and they check the clock-stop stage one edge before that.

// File: rtl/psm_pkg.sv
package psm_pkg;

   typedef enum logic [1:0] {
      PM_IDLE  = 2'd0,
      PM_WATCH = 2'd1,
      PM_SUBW  = 2'd2,
      PM_STOP  = 2'd3
   } pm_mode_e;

   typedef enum logic [2:0] {
      SQ_RUN    = 3'd0,
      SQ_LATCH  = 3'd1,
      SQ_ACCEPT = 3'd2,
      SQ_HALT   = 3'd3,
      SQ_LOWPWR = 3'd4
   } sq_state_e;

   // modes that stop the PLL and clear the clock path controls
   function automatic logic gates_clocks(pm_mode_e m);
      return m != PM_IDLE;
   endfunction

   // modes whose CPU clock code depends on the oscillator control
   function automatic logic osc_dependent(pm_mode_e m);
      return (m == PM_WATCH) || (m == PM_SUBW);
   endfunction

endpackage

// File: rtl/psm_seq.sv
module psm_seq
   import psm_pkg::*;
#(
   parameter int STOP_CYC = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stby_req,
   input  pm_mode_e  mode_in,
   input  logic      wake,
   output sq_state_e state_o,
   output pm_mode_e  mode_q,
   output logic      done_q,
   output logic      wake_apply,
   output logic      clk_stop
);

   localparam int CW = (STOP_CYC > 1) ? $clog2(STOP_CYC) : 1;
   localparam logic [CW-1:0] CNT_LOAD = CW'(STOP_CYC - 1);

   if (STOP_CYC < 1) begin : g_bad_stop
      $error("STOP_CYC must be at least 1");
   end

   sq_state_e      state_q, state_d;
   pm_mode_e       mode_d;
   logic           done_d;
   logic [CW-1:0]  cnt_q, cnt_d;

   assign wake_apply = wake && ((state_q == SQ_ACCEPT) ||
                                (state_q == SQ_HALT)   ||
                                (state_q == SQ_LOWPWR));

   always_comb begin
      state_d = state_q;
      mode_d  = mode_q;
      done_d  = done_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         SQ_RUN: begin
            if (stby_req) begin
               state_d = SQ_LATCH;
               mode_d  = mode_in;
            end
         end
         SQ_LATCH: begin
            if (wake) begin
               state_d = SQ_RUN;
            end else begin
               state_d = SQ_ACCEPT;
               done_d  = 1'b0;
            end
         end
         SQ_ACCEPT: begin
            if (wake) begin
               state_d = SQ_RUN;
            end else begin
               state_d = SQ_HALT;
               cnt_d   = CNT_LOAD;
            end
         end
         SQ_HALT: begin
            if (wake) begin
               state_d = SQ_RUN;
            end else if (cnt_q == '0) begin
               state_d = SQ_LOWPWR;
               done_d  = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         SQ_LOWPWR: begin
            if (wake) state_d = SQ_RUN;
         end
         default: state_d = SQ_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_RUN;
         mode_q  <= PM_IDLE;
         done_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         mode_q  <= mode_d;
         done_q  <= done_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state_o  = state_q;
   assign clk_stop = (state_q == SQ_LOWPWR) && gates_clocks(mode_q);

endmodule

// File: rtl/psm_cfg.sv
module psm_cfg
   import psm_pkg::*;
#(
   parameter int SW = 2,
   parameter int PW = 2,
   parameter int DW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic            wr_dma,
   input  logic            wake_apply,
   input  pm_mode_e        wake_mode,
   input  logic            osc_off,
   output logic [2:0]      ctl_q,
   output logic [2*SW-1:0] src_q,
   output logic [2:0]      cpu_q,
   output logic [3*PW-1:0] per_q
);

   localparam int NPER = 3;

   logic       wr_ok;
   logic       cpu_lock, per_lock;
   logic       clear_path;
   logic [2:0] cpu_wake;

   assign wr_ok      = wr_en && !wr_dma;
   assign clear_path = wake_apply && gates_clocks(wake_mode);
   assign cpu_wake   = osc_dependent(wake_mode) ? {osc_off, 2'b00} : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         src_q <= '0;
      end else if (clear_path) begin
         ctl_q <= '0;
         src_q <= '0;
      end else if (wr_ok) begin
         if (wr_addr == 2'd0) ctl_q <= wr_data[2:0];
         if (wr_addr == 2'd1) src_q <= wr_data[2*SW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_q    <= '0;
         cpu_lock <= 1'b0;
      end else if (wake_apply) begin
         cpu_q    <= cpu_wake;
         cpu_lock <= 1'b0;
      end else if (wr_ok && wr_addr == 2'd2 && !cpu_lock) begin
         cpu_q    <= wr_data[2:0];
         cpu_lock <= 1'b1;
      end
   end

   logic per_take;
   assign per_take = wr_ok && (wr_addr == 2'd3) && !per_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        per_lock <= 1'b0;
      else if (per_take) per_lock <= 1'b1;
   end

   for (genvar f = 0; f < NPER; f++) begin : g_per
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        per_q[f*PW +: PW] <= '0;
         else if (per_take) per_q[f*PW +: PW] <= wr_data[f*PW +: PW];
      end
   end

endmodule

// File: rtl/pwrsave_seq.sv
module pwrsave_seq
   import psm_pkg::*;
#(
   parameter int SW       = 2,
   parameter int PW       = 2,
   parameter int DW       = 6,
   parameter int STOP_CYC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stby_req,
   input  logic [1:0]      mode_sel,
   input  logic            wake,
   input  logic            osc_off,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic            wr_dma,
   output logic [2:0]      seq_stage,
   output logic            pll_stop,
   output logic            sscg_stop,
   output logic            done_flag,
   output logic [2:0]      ctl_bits,
   output logic [2*SW-1:0] src_sel,
   output logic [2:0]      cpu_code,
   output logic [3*PW-1:0] per_sel
);

   localparam int NEED_A = (3*PW > 2*SW) ? 3*PW : 2*SW;
   localparam int NEED   = (NEED_A > 3) ? NEED_A : 3;

   if (DW != NEED) begin : g_bad_dw
      $error("DW must equal the widest register field span");
   end
   if (SW < 1 || PW < 1) begin : g_bad_fw
      $error("field widths must be positive");
   end

   sq_state_e st;
   pm_mode_e  cur_mode;
   logic      wake_apply;
   logic      clk_stop;

   psm_seq #(.STOP_CYC(STOP_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .stby_req   (stby_req),
      .mode_in    (pm_mode_e'(mode_sel)),
      .wake       (wake),
      .state_o    (st),
      .mode_q     (cur_mode),
      .done_q     (done_flag),
      .wake_apply (wake_apply),
      .clk_stop   (clk_stop)
   );

   psm_cfg #(.SW(SW), .PW(PW), .DW(DW)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_dma     (wr_dma),
      .wake_apply (wake_apply),
      .wake_mode  (cur_mode),
      .osc_off    (osc_off),
      .ctl_q      (ctl_bits),
      .src_q      (src_sel),
      .cpu_q      (cpu_code),
      .per_q      (per_sel)
   );

   assign seq_stage = st;
   assign pll_stop  = clk_stop;
   assign sscg_stop = clk_stop;

endmodule

// File: rtl/psm_chk.sv
module psm_chk #(
   parameter int SW       = 2,
   parameter int PW       = 2,
   parameter int DW       = 6,
   parameter int STOP_CYC = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            stby_req,
   input logic [1:0]      mode_sel,
   input logic            wake,
   input logic            osc_off,
   input logic            wr_en,
   input logic [1:0]      wr_addr,
   input logic [DW-1:0]   wr_data,
   input logic            wr_dma,
   input logic [2:0]      seq_stage,
   input logic            pll_stop,
   input logic            sscg_stop,
   input logic            done_flag,
   input logic [2:0]      ctl_bits,
   input logic [2*SW-1:0] src_sel,
   input logic [2:0]      cpu_code,
   input logic [3*PW-1:0] per_sel
);

   logic [1:0] cap_mode;
   int         halt_cnt;
   logic       entry_live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_mode <= 2'd0;
      else if (seq_stage == 3'd0 && stby_req) cap_mode <= mode_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) halt_cnt <= 0;
      else if (seq_stage == 3'd3) halt_cnt <= halt_cnt + 1;
      else halt_cnt <= 0;
   end

   assign entry_live = (seq_stage == 3'd2) || (seq_stage == 3'd3) ||
                       (seq_stage == 3'd4);

   // R1
   latch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_stage == 3'd1 && wake) |=> (seq_stage == 3'd0 && !pll_stop &&
                                       $stable(done_flag)));

   // R2
   latch_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_stage == 3'd1 && !wake) |=> (seq_stage == 3'd2));

   // R2
   halt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_stage == 3'd3) |-> (halt_cnt < STOP_CYC));

   // R3
   early_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((seq_stage == 3'd2 || seq_stage == 3'd3) && wake) |=>
         (seq_stage == 3'd0 && !done_flag && !pll_stop && !sscg_stop));

   // R4
   accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_stage == 3'd2) |-> !done_flag);

   // R4
   lowpwr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_stage == 3'd4) |-> (done_flag && (pll_stop == (cap_mode != 2'd0))));

   // R5
   path_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_live && wake && cap_mode != 2'd0) |=> (ctl_bits == '0 && src_sel == '0));

   // R7
   osc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_live && wake && (cap_mode == 2'd1 || cap_mode == 2'd2)) |=>
         (cpu_code == {$past(osc_off), 2'b00}));

   // R10
   dma_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_stage == 3'd0 && wr_en && wr_dma) |=>
         ($stable(ctl_bits) && $stable(src_sel) && $stable(cpu_code) && $stable(per_sel)));

   // R11
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_stage == 3'd0 && !stby_req) |=> (seq_stage == 3'd0));

   // R9
   per_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_dma && wr_addr == 2'd3 && per_sel != wr_data) |=>
         (per_sel == $past(wr_data) || $stable(per_sel)));

endmodule

bind pwrsave_seq psm_chk #(.SW(SW), .PW(PW), .DW(DW), .STOP_CYC(STOP_CYC)) u_chk (.*);

// File: tb/pwrsave_seq_test.sv
module pwrsave_seq_test;

   localparam int SW = 2;
   localparam int PW = 2;
   localparam int DW = 6;
   localparam int SC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stby = 1'b0, wake = 1'b0, osc = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          wen = 1'b0, wdma = 1'b0;
   logic [1:0]    waddr = 2'd0;
   logic [DW-1:0] wdata = '0;

   logic [2:0]      stage;
   logic            pstop, sstop, done;
   logic [2:0]      ctl, cpu;
   logic [2*SW-1:0] src;
   logic [3*PW-1:0] per;

   pwrsave_seq #(.SW(SW), .PW(PW), .DW(DW), .STOP_CYC(SC)) uut (
      .clk(clk), .rst_n(rst_n), .stby_req(stby), .mode_sel(mode), .wake(wake),
      .osc_off(osc), .wr_en(wen), .wr_addr(waddr), .wr_data(wdata), .wr_dma(wdma),
      .seq_stage(stage), .pll_stop(pstop), .sscg_stop(sstop), .done_flag(done),
      .ctl_bits(ctl), .src_sel(src), .cpu_code(cpu), .per_sel(per)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   int              m_st = 0, m_cnt = 0;
   logic [1:0]      m_mode = 2'd0;
   logic            m_done = 1'b0, m_cl = 1'b0, m_pl = 1'b0;
   logic [2:0]      m_ctl = '0, m_cpu = '0;
   logic [2*SW-1:0] m_src = '0;
   logic [3*PW-1:0] m_per = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] wake_cpu(input logic [1:0] md, input logic oo);
      return (md == 2'd1 || md == 2'd2) ? {oo, 2'b00} : 3'b000;
   endfunction

   task automatic model_step();
      logic wa;
      logic wok;
      wa  = wake && (m_st >= 2);
      wok = wen && !wdma;
      if (wa && m_mode != 2'd0) begin
         m_ctl = '0;
         m_src = '0;
      end else if (wok && waddr == 2'd0) m_ctl = wdata[2:0];
      else if (wok && waddr == 2'd1) m_src = wdata[2*SW-1:0];
      if (wa) begin
         m_cpu = wake_cpu(m_mode, osc);
         m_cl  = 1'b0;
      end else if (wok && waddr == 2'd2 && !m_cl) begin
         m_cpu = wdata[2:0];
         m_cl  = 1'b1;
      end
      if (wok && waddr == 2'd3 && !m_pl) begin
         m_per = wdata;
         m_pl  = 1'b1;
      end
      case (m_st)
         0: if (stby) begin m_st = 1; m_mode = mode; end
         1: if (wake) m_st = 0; else begin m_st = 2; m_done = 1'b0; end
         2: if (wake) m_st = 0; else begin m_st = 3; m_cnt = SC - 1; end
         3: if (wake) m_st = 0;
            else if (m_cnt == 0) begin m_st = 4; m_done = 1'b1; end
            else m_cnt--;
         default: if (wake) m_st = 0;
      endcase
   endtask

   task automatic compare_all();
      logic es;
      es = (m_st == 4) && (m_mode != 2'd0);
      chk("R2 stage", 32'(stage), 32'(m_st));
      chk("R4 done", 32'(done), 32'(m_done));
      chk("R4 pll_stop", 32'(pstop), 32'(es));
      chk("R4 sscg_stop", 32'(sstop), 32'(es));
      chk("R5 ctl", 32'(ctl), 32'(m_ctl));
      chk("R5 src", 32'(src), 32'(m_src));
      chk("R8 cpu", 32'(cpu), 32'(m_cpu));
      chk("R9 per", 32'(per), 32'(m_per));
   endtask

   task automatic step();
      model_step();
      @(posedge clk);
      #2;
      compare_all();
      stby = 1'b0; wake = 1'b0; wen = 1'b0; wdma = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, input logic dm);
      wen = 1'b1; waddr = a; wdata = d; wdma = dm;
      step();
   endtask

   task automatic req(input logic [1:0] md);
      stby = 1'b1; mode = md;
      step();
   endtask

   task automatic wk();
      wake = 1'b1;
      step();
   endtask

   task automatic go(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      #2;
      // reset values (R2)
      chk("R2 reset stage", 32'(stage), 0);
      chk("R2 reset done", 32'(done), 0);
      chk("R2 reset cpu", 32'(cpu), 0);
      chk("R2 reset pll_stop", 32'(pstop), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #2;

      wr(2'd0, 6'h07, 1'b0);
      wr(2'd1, 6'h0F, 1'b0);
      wr(2'd2, 6'h05, 1'b0);
      chk("R8 first cpu write", 32'(cpu), 5);
      wr(2'd3, 6'h15, 1'b0);
      chk("R9 first per write", 32'(per), 32'h15);
      wr(2'd2, 6'h02, 1'b0);
      chk("R8 second cpu write ignored", 32'(cpu), 5);
      wr(2'd0, 6'h00, 1'b1);
      chk("R10 dma write ignored", 32'(ctl), 7);
      wr(2'd3, 6'h00, 1'b0);
      chk("R9 second per write ignored", 32'(per), 32'h15);

      // outcome 1: wake in latch
      req(2'd3);
      chk("R2 latch", 32'(stage), 1);
      wk();
      chk("R1 back to run", 32'(stage), 0);
      chk("R1 ctl kept", 32'(ctl), 7);
      chk("R1 cpu kept", 32'(cpu), 5);
      wr(2'd2, 6'h02, 1'b0);
      chk("R1 lock not re-armed", 32'(cpu), 5);

      // outcome 2: wake in accept from WATCH, osc off
      osc = 1'b1;
      req(2'd1);
      step();
      chk("R2 accept", 32'(stage), 2);
      wk();
      chk("R3 run", 32'(stage), 0);
      chk("R3 done low", 32'(done), 0);
      chk("R3 no stop", 32'(pstop), 0);
      chk("R5 ctl cleared", 32'(ctl), 0);
      chk("R5 src cleared", 32'(src), 0);
      chk("R7 osc off code", 32'(cpu), 4);
      wr(2'd2, 6'h03, 1'b0);
      chk("R8 re-armed", 32'(cpu), 3);

      // outcome 3: full STOP entry
      osc = 1'b0;
      req(2'd3);
      go(SC + 1);
      chk("R2 still halting", 32'(stage), 3);
      step();
      chk("R2 low power", 32'(stage), 4);
      chk("R4 pll stop", 32'(pstop), 1);
      chk("R4 sscg stop", 32'(sstop), 1);
      chk("R4 done set", 32'(done), 1);
      stby = 1'b1; mode = 2'd0;
      step();
      chk("R11 request in low power ignored", 32'(stage), 4);
      wk();
      chk("R6 stop wake cpu", 32'(cpu), 0);
      chk("R4 done kept", 32'(done), 1);
      wr(2'd3, 6'h2A, 1'b0);
      chk("R9 wake no re-arm", 32'(per), 32'h15);

      // IDLE full entry
      wr(2'd0, 6'h05, 1'b0);
      wr(2'd2, 6'h06, 1'b0);
      req(2'd0);
      go(SC + 2);
      chk("R2 idle low power", 32'(stage), 4);
      chk("R4 idle no stop", 32'(pstop), 0);
      wk();
      chk("R5 idle keeps ctl", 32'(ctl), 5);
      chk("R6 idle wake cpu", 32'(cpu), 0);

      // Sub-WATCH with oscillator on
      wr(2'd2, 6'h07, 1'b0);
      req(2'd2);
      go(SC + 2);
      wk();
      chk("R7 osc on code", 32'(cpu), 0);

      // R11 wake in run, request in halt, then wake in halt
      wk();
      chk("R11 wake in run ignored", 32'(stage), 0);
      req(2'd3);
      go(2);
      stby = 1'b1;
      step();
      chk("R11 request in halt ignored", 32'(stage), 3);
      wk();
      chk("R3 halt wake run", 32'(stage), 0);
      chk("R3 halt wake done", 32'(done), 0);
      chk("R3 halt wake no stop", 32'(pstop), 0);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         stby  = ($urandom % 8) == 0;
         wake  = ($urandom % 6) == 0;
         mode  = 2'($urandom);
         osc   = 1'($urandom);
         wen   = ($urandom % 3) == 0;
         wdma  = ($urandom % 4) == 0;
         waddr = 2'($urandom);
         wdata = DW'($urandom);
         step();
      end

      summary();
      $finish;
   end

endmodule